// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Encoder

This block gathers the interrupt requests of one UART channel and presents only the most urgent of them in an 8-bit status byte that software reads. Seven request sources are ranked into six fixed levels. Each level has its own enable bit. The two lowest levels are reported only when the enhanced-feature flag is set. The upper two bits of the byte show whether the channel runs with its FIFOs on. An interrupt request line is raised whenever the byte reports a pending source.

The transmit-empty request is kept in a sticky latch. A read of the status byte clears it while it is the reported source, and a write of new transmit data also clears it. The Xoff / special-character indication is latched and stays set until an Xon is seen. The status byte is a register. It is frozen while the read strobe is high, so one read returns one consistent code. It picks up the current winner on the first clock after the strobe drops, which is how a lower source becomes visible after the higher one has been serviced.

Top module: `uart_irq_encoder`

## Requirements
- R1: After synchronous reset the status byte reads 0x01 and `irq` is low.
- R2: Status bit 0 reads 0 exactly when a source is reported, and `irq` is high exactly when bit 0 is 0.
- R3: Only the highest ranked enabled source is reported in bits [5:0]. The ranks from highest to lowest, with their codes, are: line error 000110, receive time-out 001100 / data ready 000100, transmit empty 000010, modem change 000000, Xoff/special 010000, CTS/RTS change 100000. With no source pending the code is 000001.
- R4: Within the shared data level, a receive time-out is reported instead of plain data ready.
- R5: Bits [7:6] read 11 when `fifo_mode` is 1 and 00 when it is 0.
- R6: With `enh_mode` at 0, the Xoff/special and CTS/RTS sources are not reported and bits [5:4] stay 00.
- R7: A pulse on `xoff_det` sets a latch that stays set through any number of cycles until `xon_det` is pulsed. If both pulse in the same cycle, the set wins.
- R8: A pulse on `tx_empty_evt` sets a transmit-empty request that persists. The request clears when `rd_stb` is high while the byte reports 000010, or when `tx_write` is pulsed. A new empty event wins over a clear in the same cycle.
- R9: `irq_en` bits gate the levels as follows: [0] line, [1] receive data/time-out, [2] transmit empty, [3] modem, [4] Xoff/special, [5] CTS/RTS. A disabled source is not reported and does not hide a lower source.
- R10: The status byte holds its value in every cycle in which `rd_stb` is sampled high. Otherwise it takes the value implied by the inputs sampled at that clock edge, so a level input shows one clock after it is driven, and a latched event shows one clock after it is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_err | input | 1 | Receiver line-status error request (level) |
| rx_ready | input | 1 | Received data ready request (level) |
| rx_timeout | input | 1 | Receive time-out request (level) |
| tx_empty_evt | input | 1 | Pulse: transmit holding register became empty |
| tx_write | input | 1 | Pulse: new transmit data written, clears transmit-empty request |
| modem_chg | input | 1 | Modem status change request (level) |
| xoff_det | input | 1 | Pulse: Xoff or special character detected |
| xon_det | input | 1 | Pulse: Xon character received |
| flow_chg | input | 1 | CTS/RTS change-of-state request (level) |
| irq_en | input | 6 | Per-level enables, bit map in R9 |
| fifo_mode | input | 1 | FIFO mode active |
| enh_mode | input | 1 | Enhanced features active |
| rd_stb | input | 1 | Status byte read strobe |
| status | output | 8 | Encoded interrupt status byte |
| irq | output | 1 | Interrupt request, high while a source is reported |

## Verification
The priority chain is tried by raising every source at once and then removing the current winner one at a time. Each step must expose exactly the next code, which tells a wrong rank apart from a wrong encoding. Separate patterns enable and disable single levels, and toggle the enhanced and FIFO flags. These show gating and masking apart from plain priority. Read strobes are issued while sources change, once with transmit-empty reported and once with something above it, to show the hold, the read-triggered clear and the clear that must not happen. Xoff/Xon and empty/write pulses are spaced across many cycles, and some are issued together, to tell a sticky latch from a level and to check which side wins a collision.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // Sources in descending urgency; the enum order is the priority order.
    typedef enum logic [2:0] {
        SRC_LINE  = 3'd0,
        SRC_RXTO  = 3'd1,
        SRC_RXRDY = 3'd2,
        SRC_TXE   = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_XOFF  = 3'd5,
        SRC_FLOW  = 3'd6,
        SRC_NONE  = 3'd7
    } irq_src_e;

    localparam int NUM_SRC = 7;
    localparam int NUM_LVL = 6;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int CODE_W  = 6;

    localparam logic [CODE_W-1:0] CODE_LINE  = 6'b000110;
    localparam logic [CODE_W-1:0] CODE_RXTO  = 6'b001100;
    localparam logic [CODE_W-1:0] CODE_RXRDY = 6'b000100;
    localparam logic [CODE_W-1:0] CODE_TXE   = 6'b000010;
    localparam logic [CODE_W-1:0] CODE_MODEM = 6'b000000;
    localparam logic [CODE_W-1:0] CODE_XOFF  = 6'b010000;
    localparam logic [CODE_W-1:0] CODE_FLOW  = 6'b100000;
    localparam logic [CODE_W-1:0] CODE_IDLE  = 6'b000001;

    typedef struct packed {
        logic [1:0]        fifo;
        logic [CODE_W-1:0] code;
    } irq_status_t;

    function automatic logic [CODE_W-1:0] src_code(irq_src_e s);
        case (s)
            SRC_LINE:  return CODE_LINE;
            SRC_RXTO:  return CODE_RXTO;
            SRC_RXRDY: return CODE_RXRDY;
            SRC_TXE:   return CODE_TXE;
            SRC_MODEM: return CODE_MODEM;
            SRC_XOFF:  return CODE_XOFF;
            SRC_FLOW:  return CODE_FLOW;
            default:   return CODE_IDLE;
        endcase
    endfunction

    // Enable bit that governs each source.
    function automatic logic [LVL_W-1:0] src_level(irq_src_e s);
        case (s)
            SRC_LINE:             return 3'd0;
            SRC_RXTO, SRC_RXRDY:  return 3'd1;
            SRC_TXE:              return 3'd2;
            SRC_MODEM:            return 3'd3;
            SRC_XOFF:             return 3'd4;
            default:              return 3'd5;
        endcase
    endfunction

    // Sources that exist only with enhanced features on.
    function automatic logic src_extended(irq_src_e s);
        return (s == SRC_XOFF) || (s == SRC_FLOW);
    endfunction

endpackage

// File: rtl/uart_irq_pend.sv
module uart_irq_pend (
    input  logic clk,
    input  logic rst,
    input  logic tx_empty_evt,
    input  logic tx_write,
    input  logic tx_read_clr,
    input  logic xoff_det,
    input  logic xon_det,
    output logic tx_pend,
    output logic xoff_hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_pend   <= 1'b0;
            xoff_hold <= 1'b0;
        end else begin
            if (tx_empty_evt)
                tx_pend <= 1'b1;
            else if (tx_write || tx_read_clr)
                tx_pend <= 1'b0;

            if (xoff_det)
                xoff_hold <= 1'b1;
            else if (xon_det)
                xoff_hold <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output irq_src_e           winner
);
    // Scan from lowest to highest so the most urgent request overwrites.
    always_comb begin
        winner = SRC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i])
                winner = irq_src_e'(3'(i));
        end
    end
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
    import uart_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               line_err,
    input  logic               rx_ready,
    input  logic               rx_timeout,
    input  logic               tx_empty_evt,
    input  logic               tx_write,
    input  logic               modem_chg,
    input  logic               xoff_det,
    input  logic               xon_det,
    input  logic               flow_chg,
    input  logic [NUM_LVL-1:0] irq_en,
    input  logic               fifo_mode,
    input  logic               enh_mode,
    input  logic               rd_stb,
    output logic [7:0]         status,
    output logic               irq
);
    irq_status_t        status_q;
    logic               tx_pend;
    logic               xoff_hold;
    logic               tx_read_clr;
    logic [NUM_SRC-1:0] req_raw;
    logic [NUM_SRC-1:0] req_gated;
    irq_src_e           winner;

    assign tx_read_clr = rd_stb && (status_q.code == CODE_TXE);

    uart_irq_pend u_pend (
        .clk          (clk),
        .rst          (rst),
        .tx_empty_evt (tx_empty_evt),
        .tx_write     (tx_write),
        .tx_read_clr  (tx_read_clr),
        .xoff_det     (xoff_det),
        .xon_det      (xon_det),
        .tx_pend      (tx_pend),
        .xoff_hold    (xoff_hold)
    );

    always_comb begin
        req_raw            = '0;
        req_raw[SRC_LINE]  = line_err;
        req_raw[SRC_RXTO]  = rx_timeout;
        req_raw[SRC_RXRDY] = rx_ready;
        req_raw[SRC_TXE]   = tx_pend;
        req_raw[SRC_MODEM] = modem_chg;
        req_raw[SRC_XOFF]  = xoff_hold;
        req_raw[SRC_FLOW]  = flow_chg;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        localparam irq_src_e SRC = irq_src_e'(3'(g));
        if (src_extended(SRC)) begin : g_ext
            assign req_gated[g] = req_raw[g] & irq_en[src_level(SRC)] & enh_mode;
        end else begin : g_base
            assign req_gated[g] = req_raw[g] & irq_en[src_level(SRC)];
        end
    end

    uart_irq_prio u_prio (
        .req    (req_gated),
        .winner (winner)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '{fifo: 2'b00, code: CODE_IDLE};
        end else if (!rd_stb) begin
            status_q <= '{fifo: {2{fifo_mode}}, code: src_code(winner)};
        end
    end

    assign status = status_q;
    assign irq    = ~status_q.code[0];
endmodule

// File: rtl/uart_irq_encoder_chk.sv
module uart_irq_encoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       line_err,
    input logic [5:0] irq_en,
    input logic       fifo_mode,
    input logic       enh_mode,
    input logic       rd_stb,
    input logic [7:0] status,
    input logic       irq
);
    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (status == 8'h01 && !irq));

    // R5
    fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> (status[7:6] == {2{$past(fifo_mode)}}));

    // R6
    enh_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!enh_mode && !rd_stb) |=> (status[5:4] == 2'b00));

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> $stable(status));

    // R3
    line_top_chk: assert property (@(posedge clk) disable iff (rst)
        (line_err && irq_en[0] && !rd_stb) |=> (status[5:0] == 6'b000110));

    // R3
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (status[5:0] inside {6'b000110, 6'b001100, 6'b000100, 6'b000010,
                             6'b000000, 6'b010000, 6'b100000, 6'b000001}));
endmodule

bind uart_irq_encoder uart_irq_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_err  (line_err),
    .irq_en    (irq_en),
    .fifo_mode (fifo_mode),
    .enh_mode  (enh_mode),
    .rd_stb    (rd_stb),
    .status    (status),
    .irq       (irq)
);

// File: tb/uart_irq_encoder_bench.sv
module uart_irq_encoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_err = 0, rx_ready = 0, rx_timeout = 0;
    logic       tx_empty_evt = 0, tx_write = 0, modem_chg = 0;
    logic       xoff_det = 0, xon_det = 0, flow_chg = 0;
    logic [5:0] irq_en = 6'h3f;
    logic       fifo_mode = 0, enh_mode = 1, rd_stb = 0;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // Reference state
    logic [7:0] exp_status = 8'h01;
    bit         m_tx = 0;
    bit         m_xoff = 0;

    always #10 clk = ~clk;

    uart_irq_encoder u_uart_irq_encoder (
        .clk(clk), .rst(rst), .line_err(line_err), .rx_ready(rx_ready),
        .rx_timeout(rx_timeout), .tx_empty_evt(tx_empty_evt), .tx_write(tx_write),
        .modem_chg(modem_chg), .xoff_det(xoff_det), .xon_det(xon_det),
        .flow_chg(flow_chg), .irq_en(irq_en), .fifo_mode(fifo_mode),
        .enh_mode(enh_mode), .rd_stb(rd_stb), .status(status), .irq(irq)
    );

    function automatic logic [5:0] ref_code();
        if (line_err && irq_en[0])                 return 6'b000110;
        if (rx_timeout && irq_en[1])               return 6'b001100;
        if (rx_ready && irq_en[1])                 return 6'b000100;
        if (m_tx && irq_en[2])                     return 6'b000010;
        if (modem_chg && irq_en[3])                return 6'b000000;
        if (m_xoff && irq_en[4] && enh_mode)       return 6'b010000;
        if (flow_chg && irq_en[5] && enh_mode)     return 6'b100000;
        return 6'b000001;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_status = 8'h01;
            m_tx = 0;
            m_xoff = 0;
        end else begin
            bit read_clr;
            read_clr = rd_stb && (exp_status[5:0] == 6'b000010);
            if (!rd_stb)
                exp_status = {fifo_mode ? 2'b11 : 2'b00, ref_code()};
            if (tx_empty_evt) m_tx = 1;
            else if (tx_write || read_clr) m_tx = 0;
            if (xoff_det) m_xoff = 1;
            else if (xon_det) m_xoff = 0;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (status !== exp_status) begin
                errors++;
                $display("FAIL %s status=%h expected=%h", tag, status, exp_status);
            end
            checks++;
            if (irq !== ~exp_status[0]) begin   // R2
                errors++;
                $display("FAIL R2 irq=%b expected=%b", irq, ~exp_status[0]);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx_empty();
        tx_empty_evt = 1; step(1); tx_empty_evt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset value
        tag = "R1";
        step(3);
        rst = 0;
        step(2);

        // R3 all sources at once, remove winners one by one
        tag = "R3";
        line_err = 1; rx_ready = 1; rx_timeout = 1; modem_chg = 1; flow_chg = 1;
        xoff_det = 1; pulse_tx_empty(); xoff_det = 0;
        step(2);
        line_err = 0; step(2);
        tag = "R4"; rx_timeout = 0; step(2);
        tag = "R3"; rx_ready = 0; step(2);
        tx_write = 1; step(1); tx_write = 0; step(2);   // R8 write clears
        modem_chg = 0; step(2);
        tag = "R7"; step(5); xon_det = 1; step(1); xon_det = 0; step(2);
        tag = "R3"; flow_chg = 0; step(2);

        // R5 fifo bits
        tag = "R5";
        fifo_mode = 1; step(2); modem_chg = 1; step(2); fifo_mode = 0; step(2);
        modem_chg = 0; step(2);

        // R6 enhanced flag masks levels 5 and 6
        tag = "R6";
        enh_mode = 0; flow_chg = 1; xoff_det = 1; step(1); xoff_det = 0; step(3);
        enh_mode = 1; step(2);          // latched Xoff now visible
        tag = "R7"; xoff_det = 1; xon_det = 1; step(1); xoff_det = 0; xon_det = 0; step(2);
        xon_det = 1; step(1); xon_det = 0; step(2);
        flow_chg = 0; step(2);

        // R8 read clears transmit empty only while reported
        tag = "R8";
        pulse_tx_empty(); step(2);
        rd_stb = 1; step(1); rd_stb = 0; step(3);
        pulse_tx_empty(); line_err = 1; step(2);
        rd_stb = 1; step(1); rd_stb = 0; step(2);   // TX not reported, stays
        line_err = 0; step(2);
        tx_empty_evt = 1; tx_write = 1; step(1); tx_empty_evt = 0; tx_write = 0; step(2);
        rd_stb = 1; step(1); rd_stb = 0; step(2);

        // R10 hold during read
        tag = "R10";
        rd_stb = 1; line_err = 1; step(3); modem_chg = 1; step(2); rd_stb = 0;
        step(2); line_err = 0; step(2); modem_chg = 0; step(2);

        // R9 enable gating
        tag = "R9";
        line_err = 1; modem_chg = 1; irq_en = 6'b111110; step(3);
        irq_en = 6'b110110; step(2);
        irq_en = 6'b000000; step(2);
        irq_en = 6'h3f; step(2);
        line_err = 0; modem_chg = 0; step(2);
        rx_ready = 1; rx_timeout = 1; irq_en = 6'b111101; step(2);
        irq_en = 6'h3f; step(2);
        rx_timeout = 0; step(2); rx_ready = 0; step(2);

        // R1 reset in the middle of activity
        tag = "R1";
        line_err = 1; xoff_det = 1; step(1); xoff_det = 0; fifo_mode = 1;
        rst = 1; line_err = 0; step(2); rst = 0; fifo_mode = 0; step(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule